// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides a fast input clock, coming from a VCO directly or through an external prescaler, by a programmable ratio N. It emits one active-low pulse per division period on `fvn_n`. It also drives `mod_out`, which selects the ratio of an external P/P+1 prescaler.

In dual mode, `mod_out` is low for the first A input cycles of every period and high for the rest. The prescaler therefore divides by P+1 A times and by P for the other N−A times. This gives a VCO frequency of (P·N + A) times the comparison rate. In single mode only the N counter matters, and `mod_out` stays high.

The ratio, swallow count and mode are captured together at the start of each period, so a reprogram never tears a period in half. An A that would not fit inside the period is cut to N−1 and reported on `a_clamped`.

Top module: `pswallow_div`

## Requirements
- R1: While `rst_n` is low, `fvn_n` and `mod_out` are high and `a_clamped` is low.
- R2: While running, `fvn_n` is low for exactly one input cycle in each period of N cycles, in the last cycle of that period. `n_prog` = 0 gives N = 4096, and N = 1 holds `fvn_n` low in every cycle.
- R3: In dual mode (`dual_sel` = 1), `mod_out` is low in the first A cycles of a period and high from cycle A through the period's last cycle. `mod_out` is always high while `fvn_n` is low.
- R4: `a_prog` = 0 stands for A = 128 swallow cycles.
- R5: In single mode (`dual_sel` = 0), `mod_out` stays high and `a_clamped` stays low.
- R6: `n_prog`, `a_prog` and `dual_sel` are sampled only on the edge that starts a period. A change in the middle of a period alters neither the current period's length nor its `mod_out` pattern.
- R7: In dual mode, an effective A of N or more is replaced by N−1. `a_clamped` is then high for the whole of that period.
- R8: While `en` is low, `fvn_n` and `mod_out` are high. After the first rising clock edge that samples `en` high, a fresh period starts: that edge's cycle is cycle 0, and `fvn_n` is low in cycle N−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast divider input clock (VCO or prescaler output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the counters at reload |
| dual_sel | input | 1 | 1 selects dual modulus, 0 single modulus |
| n_prog | input | 12 | Division ratio N (0 means 4096) |
| a_prog | input | 7 | Swallow count A (0 means 128) |
| fvn_n | output | 1 | Divided output, one-cycle active-low pulse per period |
| mod_out | output | 1 | Prescaler modulus select, low selects P+1 |
| a_clamped | output | 1 | High when the loaded A was cut to N−1 |

## Verification
Every output is compared cycle by cycle against a phase-counting model.

The directed patterns each isolate one behaviour:
- A small single-mode ratio checks the pulse spacing alone.
- A dual-mode ratio with a short A shows the low-then-high shape of `mod_out`.
- N = 200 with A = 0 separates the 128-cycle meaning of zero from a literal zero.
- A = 12 against N = 8 exposes the clamp and its flag.
- N = 1 and N = 0 (4096) cover the extremes of the period.

A reprogram in the middle of a period shows whether new values leak in before the reload. Toggling `en` shows the restart point. Randomly timed value changes, mode flips and enable drops then mix all of these at unaligned phases.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } mod_mode_e;

endpackage

// File: rtl/pswallow_cfg.sv
// Turns the programmed values into the effective period length and swallow
// count: zero codes mean full scale, and A is cut to N-1 when it would not fit.
module pswallow_cfg
  import pswallow_pkg::*;
#(
  parameter int N_W = 12,
  parameter int A_W = 7
) (
  input  logic [N_W-1:0] n_prog,
  input  logic [A_W-1:0] a_prog,
  input  mod_mode_e      mode,
  output logic [N_W:0]   n_eff,
  output logic [A_W:0]   a_eff,
  output logic           a_over
);
  localparam int CNT_W  = N_W + 1;
  localparam int AE_W   = A_W + 1;
  localparam int N_FULL = 1 << N_W;
  localparam int A_FULL = 1 << A_W;

  logic [AE_W-1:0]  a_raw;
  logic [CNT_W-1:0] a_wide;

  always_comb begin
    n_eff  = (n_prog == '0) ? CNT_W'(N_FULL) : {1'b0, n_prog};
    a_raw  = (a_prog == '0) ? AE_W'(A_FULL) : {1'b0, a_prog};
    a_wide = CNT_W'(a_raw);
    a_over = 1'b0;
    a_eff  = a_raw;
    if (mode == MODE_SINGLE) begin
      a_eff = '0;
    end else if (a_wide >= n_eff) begin
      // n_eff <= A_FULL here, so its low AE_W bits hold it exactly
      a_over = 1'b1;
      a_eff  = n_eff[AE_W-1:0] - AE_W'(1);
    end
  end

endmodule

// File: rtl/pswallow_ncnt.sv
// Period counter: runs from N down to 1; the cycle at 1 is the period's last.
module pswallow_ncnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = reload | ~last;
    cnt_d  = reload ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pswallow_acnt.sv
// Swallow counter: loaded at reload, counts down to zero and then rests.
module pswallow_acnt #(
  parameter int AE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [AE_W-1:0] load_val,
  output logic            nonzero
);
  logic [AE_W-1:0] cnt_q;
  logic [AE_W-1:0] cnt_d;
  logic            cnt_ce;

  always_comb begin
    cnt_ce = reload | nonzero;
    cnt_d  = reload ? load_val : (cnt_q - AE_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int N_W = 12,
  parameter int A_W = 7
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic           en,
  input  logic           dual_sel,
  input  logic [N_W-1:0] n_prog,
  input  logic [A_W-1:0] a_prog,
  output logic           fvn_n,
  output logic           mod_out,
  output logic           a_clamped
);
  localparam int CNT_W = N_W + 1;
  localparam int AE_W  = A_W + 1;

  logic            run_q;
  mod_mode_e       dual_q;
  mod_mode_e       dual_d;
  logic            bad_q;
  logic            bad_d;
  logic            reload;
  logic            active;
  logic            n_last;
  logic            a_nz;
  logic [CNT_W-1:0] n_eff;
  logic [AE_W-1:0]  a_eff;
  logic             a_over;
  mod_mode_e        mode_in;

  assign mode_in = mod_mode_e'(dual_sel);

  pswallow_cfg #(.N_W(N_W), .A_W(A_W)) u_cfg (
    .n_prog (n_prog),
    .a_prog (a_prog),
    .mode   (mode_in),
    .n_eff  (n_eff),
    .a_eff  (a_eff),
    .a_over (a_over)
  );

  pswallow_ncnt #(.CNT_W(CNT_W)) u_ncnt (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .reload   (reload),
    .load_val (n_eff),
    .last     (n_last)
  );

  pswallow_acnt #(.AE_W(AE_W)) u_acnt (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .reload   (reload),
    .load_val (a_eff),
    .nonzero  (a_nz)
  );

  // Reload while idle, on the first edge after an enable, or at period end.
  always_comb begin
    reload = ~run_q | ~en | n_last;
    active = run_q & en;
    dual_d = reload ? mode_in : dual_q;
    bad_d  = reload ? a_over : bad_q;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      dual_q <= MODE_SINGLE;
      bad_q  <= 1'b0;
    end else begin
      run_q  <= en;
      dual_q <= dual_d;
      bad_q  <= bad_d;
    end
  end

  assign fvn_n     = ~(active & n_last);
  assign mod_out   = ~(active & (dual_q == MODE_DUAL) & a_nz);
  assign a_clamped = bad_q;

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic run_q,
  input logic dual_q,
  input logic fvn_n,
  input logic mod_out,
  input logic a_clamped
);

  p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (fvn_n && mod_out));

  p_mod_high_at_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fvn_n |-> mod_out);

  p_mod_falls_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_out) && $past(en) && $past(run_q)) |-> $past(!fvn_n));

  p_single_mod_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> mod_out);

  p_flag_only_dual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_clamped |-> dual_q);

endmodule

bind pswallow_div pswallow_div_chk u_chk (
  .clk       (clk_in),
  .rst_n     (rst_n),
  .en        (en),
  .run_q     (run_q),
  .dual_q    (dual_q),
  .fvn_n     (fvn_n),
  .mod_out   (mod_out),
  .a_clamped (a_clamped)
);

// File: tb/pswallow_div_tb.sv
`timescale 1ns/1ps
module pswallow_div_tb;
  logic        clk_in = 1'b0;
  logic        rst_n  = 1'b0;
  logic        en     = 1'b0;
  logic        dual_sel = 1'b0;
  logic [11:0] n_prog = 12'd5;
  logic [6:0]  a_prog = 7'd1;
  logic        fvn_n, mod_out, a_clamped;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  // bench reference state
  bit run_m = 1'b0, dl = 1'b0, bl = 1'b0;
  int k = 0, nl = 1, al = 0;

  always #2.5 clk_in = ~clk_in;

  pswallow_div u_dut (
    .clk_in (clk_in), .rst_n (rst_n), .en (en), .dual_sel (dual_sel),
    .n_prog (n_prog), .a_prog (a_prog),
    .fvn_n (fvn_n), .mod_out (mod_out), .a_clamped (a_clamped)
  );

  function automatic int f_n(input logic [11:0] n);
    return (n == 0) ? 4096 : int'(n);
  endfunction

  function automatic int f_a(input logic [6:0] a, input logic [11:0] n, input bit d);
    int swl = (a == 0) ? 128 : int'(a);
    if (!d) return 0;
    return (swl >= f_n(n)) ? f_n(n) - 1 : swl;
  endfunction

  function automatic bit f_bad(input logic [6:0] a, input logic [11:0] n, input bit d);
    int swl = (a == 0) ? 128 : int'(a);
    return d && (swl >= f_n(n));
  endfunction

  always @(posedge clk_in) begin
    if (!rst_n) begin
      run_m = 1'b0; dl = 1'b0; bl = 1'b0; k = 0; nl = 1; al = 0;
    end else begin
      if (!run_m || !en || k == nl - 1) begin
        nl = f_n(n_prog); al = f_a(a_prog, n_prog, dual_sel);
        dl = dual_sel; bl = f_bad(a_prog, n_prog, dual_sel); k = 0;
      end else begin
        k = k + 1;
      end
      run_m = en;
    end
    chk_on = 1'b1;
  end

  task automatic check_bit(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b (k=%0d n=%0d a=%0d)",
               tag, what, act, exp, k, nl, al);
    end
  endtask

  always @(negedge clk_in) begin
    if (chk_on && !done) begin
      bit act_m;
      act_m = en && run_m && rst_n;
      check_bit("fvn_n", fvn_n, !(act_m && k == nl - 1));
      check_bit("mod_out", mod_out, !(act_m && dl && k < al));
      check_bit("a_clamped", a_clamped, rst_n ? bl : 1'b0);
    end
  end

  task automatic apply(input int n, input int a, input bit d, input bit e,
                       input int cycles, input string t);
    @(posedge clk_in); #1;
    n_prog = 12'(n); a_prog = 7'(a); dual_sel = d; en = e; tag = t;
    repeat (cycles) @(posedge clk_in);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired tag=%s", tag);
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    // R1: reset state
    repeat (4) @(posedge clk_in);
    #1 rst_n = 1'b1;
    apply(5, 1, 0, 0, 3, "R8");
    // R2 / R5: single mode pulse spacing
    apply(5, 3, 0, 1, 20, "R5");
    apply(7, 9, 0, 1, 22, "R2");
    // R3: dual mode, short swallow
    apply(10, 3, 1, 1, 35, "R3");
    // R4: A=0 means 128
    apply(200, 0, 1, 1, 410, "R4");
    // R7: clamp A to N-1
    apply(8, 12, 1, 1, 25, "R7");
    apply(100, 0, 1, 1, 210, "R7");
    // R2 extremes
    apply(1, 0, 0, 1, 6, "R2");
    apply(1, 5, 1, 1, 6, "R7");
    apply(0, 4, 1, 1, 4100, "R2");
    // R6: mid-period reprogram
    apply(20, 5, 1, 1, 27, "R6");
    apply(9, 2, 0, 1, 30, "R6");
    apply(15, 6, 1, 1, 8, "R6");
    apply(4, 1, 0, 1, 40, "R6");
    // R8: enable drop and restart
    apply(6, 2, 1, 0, 5, "R8");
    apply(6, 2, 1, 1, 14, "R8");
    apply(6, 2, 1, 0, 1, "R8");
    apply(6, 2, 1, 1, 14, "R8");
    // random mix
    for (int i = 0; i < 300; i++) begin
      apply($urandom_range(40, 1), $urandom_range(50, 0), 1'($urandom_range(1, 0)),
            $urandom_range(9, 0) != 0, $urandom_range(60, 1), "R6");
    end
    apply(5, 1, 0, 0, 3, "R8");
    finish_run();
  end
endmodule